// File: doc/BRIEF.md
# Raster Timing and 8-bit Indexed Scanout Engine

This block turns four byte-writable control registers into a running raster. It counts pixels across each line and lines down each frame, marks the blanking interval, and for every visible pixel issues a byte address into an 8-bit-per-pixel frame buffer. The byte that comes back from the buffer leaves the block as a palette index, with blanking aligned to it.

Horizontal sizes are held in units of eight pixels and every total or display count is stored one below its real value. The frame start is held in units of eight bytes and the line stride in units of four bytes. The stored register bytes are only turned into live timing when software writes the offset/pitch register or the general-control register. Scanout needs both a native-mode bit and a raster-enable bit. A display-off bit, or any pixel format other than 8-bit indexed, forces the index to zero while the timing keeps running. The frame buffer is a synchronous memory with a read latency of `RD_LAT` cycles.

Top module: `crtc_scanout`

## Requirements
- R1: Line length in clocks is (H+1)*8, where H is the 9-bit value {horizontal byte 1 bit 0, horizontal byte 0}. Each line shows (D+1)*8 visible pixels, where D is horizontal byte 2. The pixel counter returns to 0 after its last count.
- R2: A frame has V+1 lines, where V is {vertical byte 1 bits 2:0, vertical byte 0}. Lines 0 to E are visible, where E is {vertical byte 3 bits 2:0, vertical byte 2}. The time from the first visible line of one frame to the first visible line of the next is (V+1) line lengths.
- R3: The fetch address of pixel x on line y is S*8 + y*P*4 + x, modulo 2^ADDR_W. S is {offset byte 2 bits 3:0, byte 1, byte 0}. P is {offset byte 3, offset byte 2 bits 7:6}.
- R4: The output index is the memory byte read at the pixel's fetch address, and visible pixels leave in raster order. The index is 0 whenever blank_o is high.
- R5: Scanout runs only when general-control byte 3 has bit 0 (native mode) and bit 1 (raster enable) both set. Otherwise the counters are held at zero, blank_o stays 1 and no fetch is issued.
- R6: When general-control byte 0 bit 6 (display off) is set, every pixel is index 0, while blanking keeps its normal timing.
- R7: General-control byte 1 bits 2:0 select the format, and code 2 is 8-bit indexed. With any other code, every pixel is 0 and fmt_bad_o is 1 while scanout runs.
- R8: A write to the horizontal or vertical register has no effect on the raster until a later write to the offset/pitch or general-control register.
- R9: After reset, blank_o=1, pix_o=0, mem_rd_o=0 and fmt_bad_o=0.
- R10: Register bytes are addressed by wr_addr: bits 3:2 pick the register (0 horizontal, 1 vertical, 2 offset/pitch, 3 general control) and bits 1:0 pick the byte lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 4 | Register select and byte lane |
| wr_data | input | 8 | Byte to write |
| mem_addr_o | output | ADDR_W | Frame-buffer byte address |
| mem_rd_o | output | 1 | Fetch request for a visible pixel |
| mem_data_i | input | 8 | Frame-buffer byte, RD_LAT cycles after the request |
| blank_o | output | 1 | High outside the visible area |
| pix_o | output | 8 | Palette index for the current pixel |
| fmt_bad_o | output | 1 | High while scanning with an unsupported format |

## Verification
The assertions check on every cycle that the pixel counter steps by one and wraps at its total, that the line counter wraps at the vertical total and reloads the row base, and that the row base advances by the stride. They also check that no fetch is issued while scanout is gated off and that the index is zero during blanking. Only the bench scenarios show the decoded field positions: the upper bits of the horizontal and vertical totals, the split pitch field and the high start nibble. The bench also shows the deferred effect of horizontal writes and the black output for display-off and bad formats, by comparing every visible pixel against memory contents computed from the address formula.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int H_FLD_W  = 9;
  localparam int HD_FLD_W = 8;
  localparam int V_FLD_W  = 11;
  localparam int ST_FLD_W = 20;
  localparam int PT_FLD_W = 10;
  localparam int HCNT_W   = H_FLD_W + 3;
  localparam logic [2:0] FMT_IDX8 = 3'd2;

  typedef enum logic [1:0] {
    SEL_HORZ    = 2'd0,
    SEL_VERT    = 2'd1,
    SEL_OFFPTCH = 2'd2,
    SEL_GENCTL  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [H_FLD_W-1:0]  htot;
    logic [HD_FLD_W-1:0] hdisp;
    logic [V_FLD_W-1:0]  vtot;
    logic [V_FLD_W-1:0]  vdisp;
    logic [ST_FLD_W-1:0] start;
    logic [PT_FLD_W-1:0] pitch;
    logic [2:0]          fmt;
    logic                native;
    logic                crtc_on;
    logic                disp_off;
  } crtc_cfg_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int NBYTE  = 4,
  localparam int SEL_W  = $clog2(NREG),
  localparam int LANE_W = $clog2(NBYTE)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SEL_W+LANE_W-1:0]  wr_addr,
  input  logic [7:0]               wr_data,
  output crtc_cfg_t                cfg_o
);
  logic [7:0] raw [NREG][NBYTE];
  logic       redo;
  reg_sel_e   sel;

  assign sel = reg_sel_e'(wr_addr[SEL_W+LANE_W-1:LANE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++)
        for (int b = 0; b < NBYTE; b++)
          raw[r][b] <= '0;
      redo <= 1'b0;
    end else begin
      if (wr_en)
        raw[wr_addr[SEL_W+LANE_W-1:LANE_W]][wr_addr[LANE_W-1:0]] <= wr_data;
      redo <= wr_en && (sel == SEL_OFFPTCH || sel == SEL_GENCTL);
    end
  end

  crtc_cfg_t dec;
  always_comb begin
    dec.htot     = {raw[SEL_HORZ][1][0], raw[SEL_HORZ][0]};
    dec.hdisp    = raw[SEL_HORZ][2];
    dec.vtot     = {raw[SEL_VERT][1][2:0], raw[SEL_VERT][0]};
    dec.vdisp    = {raw[SEL_VERT][3][2:0], raw[SEL_VERT][2]};
    dec.start    = {raw[SEL_OFFPTCH][2][3:0], raw[SEL_OFFPTCH][1], raw[SEL_OFFPTCH][0]};
    dec.pitch    = {raw[SEL_OFFPTCH][3], raw[SEL_OFFPTCH][2][7:6]};
    dec.fmt      = raw[SEL_GENCTL][1][2:0];
    dec.native   = raw[SEL_GENCTL][3][0];
    dec.crtc_on  = raw[SEL_GENCTL][3][1];
    dec.disp_off = raw[SEL_GENCTL][0][6];
  end

  logic unused_raw;
  assign unused_raw = ^{raw[SEL_HORZ][1][7:1], raw[SEL_HORZ][3], raw[SEL_VERT][1][7:3],
                        raw[SEL_VERT][3][7:3], raw[SEL_OFFPTCH][2][5:4], raw[SEL_GENCTL][0][5:0],
                        raw[SEL_GENCTL][0][7], raw[SEL_GENCTL][1][7:3], raw[SEL_GENCTL][2],
                        raw[SEL_GENCTL][3][7:2]};

  always_ff @(posedge clk) begin
    if (rst)       cfg_o <= '0;
    else if (redo) cfg_o <= dec;
  end
endmodule

// File: rtl/crtc_counters.sv
module crtc_counters
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic [H_FLD_W-1:0]  htot_i,
  input  logic [HD_FLD_W-1:0] hdisp_i,
  input  logic [V_FLD_W-1:0]  vtot_i,
  input  logic [V_FLD_W-1:0]  vdisp_i,
  input  logic [ST_FLD_W-1:0] start_i,
  input  logic [PT_FLD_W-1:0] pitch_i,
  output logic [HCNT_W-1:0]   hcnt_o,
  output logic [V_FLD_W-1:0]  vcnt_o,
  output logic [ADDR_W-1:0]   row_base_o,
  output logic [ADDR_W-1:0]   fetch_addr_o,
  output logic                fetch_vld_o
);
  localparam int ST_B_W = ST_FLD_W + 3;
  localparam int PT_B_W = PT_FLD_W + 2;

  logic [HCNT_W-1:0] h_last, hd_last;
  logic [ADDR_W-1:0] start_b, stride_b, hcnt_ext;
  logic              h_end, v_end, visible;

  assign h_last   = {htot_i, 3'b111};
  assign hd_last  = {{(HCNT_W-HD_FLD_W-3){1'b0}}, hdisp_i, 3'b111};
  assign start_b  = {{(ADDR_W-ST_B_W){1'b0}}, start_i, 3'b000};
  assign stride_b = {{(ADDR_W-PT_B_W){1'b0}}, pitch_i, 2'b00};
  assign hcnt_ext = {{(ADDR_W-HCNT_W){1'b0}}, hcnt_o};
  assign h_end    = hcnt_o >= h_last;
  assign v_end    = vcnt_o >= vtot_i;
  assign visible  = (hcnt_o <= hd_last) && (vcnt_o <= vdisp_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      hcnt_o       <= '0;
      vcnt_o       <= '0;
      row_base_o   <= start_b;
      fetch_addr_o <= '0;
      fetch_vld_o  <= 1'b0;
    end else begin
      fetch_vld_o  <= visible;
      fetch_addr_o <= row_base_o + hcnt_ext;
      if (h_end) begin
        hcnt_o <= '0;
        if (v_end) begin
          vcnt_o     <= '0;
          row_base_o <= start_b;
        end else begin
          vcnt_o     <= vcnt_o + 1'b1;
          row_base_o <= row_base_o + stride_b;
        end
      end else begin
        hcnt_o <= hcnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crtc_pixel_out.sv
module crtc_pixel_out #(
  parameter int RD_LAT = 1,
  parameter int PIX_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_vld_i,
  input  logic             show_i,
  input  logic             run_i,
  input  logic             fmt_ok_i,
  input  logic [PIX_W-1:0] mem_data_i,
  output logic             blank_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             fmt_bad_o
);
  logic vld_p  [RD_LAT];
  logic show_p [RD_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_p[0]  <= 1'b0;
      show_p[0] <= 1'b0;
    end else begin
      vld_p[0]  <= fetch_vld_i;
      show_p[0] <= show_i;
    end
  end

  for (genvar g = 1; g < RD_LAT; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_p[g]  <= 1'b0;
        show_p[g] <= 1'b0;
      end else begin
        vld_p[g]  <= vld_p[g-1];
        show_p[g] <= show_p[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_o   <= 1'b1;
      pix_o     <= '0;
      fmt_bad_o <= 1'b0;
    end else begin
      blank_o   <= !vld_p[RD_LAT-1];
      pix_o     <= (vld_p[RD_LAT-1] && show_p[RD_LAT-1]) ? mem_data_i : '0;
      fmt_bad_o <= run_i && !fmt_ok_i;
    end
  end
endmodule

// File: rtl/crtc_scanout.sv
module crtc_scanout
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int RD_LAT = 1,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [PIX_W-1:0]  mem_data_i,
  output logic              blank_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              fmt_bad_o
);
  crtc_cfg_t         cfg;
  logic              run_w, show_w, fmt_ok_w;
  logic [HCNT_W-1:0] hcnt_w;
  logic [V_FLD_W-1:0] vcnt_w;
  logic [ADDR_W-1:0] row_base_w;

  crtc_regs #(.NREG(4), .NBYTE(4)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg)
  );

  assign run_w    = cfg.native && cfg.crtc_on;
  assign fmt_ok_w = cfg.fmt == FMT_IDX8;
  assign show_w   = fmt_ok_w && !cfg.disp_off;

  crtc_counters #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(run_w),
    .htot_i(cfg.htot), .hdisp_i(cfg.hdisp), .vtot_i(cfg.vtot), .vdisp_i(cfg.vdisp),
    .start_i(cfg.start), .pitch_i(cfg.pitch),
    .hcnt_o(hcnt_w), .vcnt_o(vcnt_w), .row_base_o(row_base_w),
    .fetch_addr_o(mem_addr_o), .fetch_vld_o(mem_rd_o)
  );

  crtc_pixel_out #(.RD_LAT(RD_LAT), .PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst(rst), .fetch_vld_i(mem_rd_o), .show_i(show_w),
    .run_i(run_w), .fmt_ok_i(fmt_ok_w), .mem_data_i(mem_data_i),
    .blank_o(blank_o), .pix_o(pix_o), .fmt_bad_o(fmt_bad_o)
  );
endmodule

// File: rtl/crtc_scanout_chk.sv
module crtc_scanout_chk
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PIX_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                run,
  input logic [H_FLD_W-1:0]  htot,
  input logic [V_FLD_W-1:0]  vtot,
  input logic [ST_FLD_W-1:0] start,
  input logic [PT_FLD_W-1:0] pitch,
  input logic [HCNT_W-1:0]   hcnt,
  input logic [V_FLD_W-1:0]  vcnt,
  input logic [ADDR_W-1:0]   row_base,
  input logic                mem_rd_o,
  input logic                blank_o,
  input logic [PIX_W-1:0]    pix_o,
  input logic                fmt_bad_o
);
  logic [HCNT_W-1:0] h_last;
  logic [ADDR_W-1:0] start_b, stride_b;
  logic              line_end;
  assign h_last   = {htot, 3'b111};
  assign start_b  = ADDR_W'({start, 3'b000});
  assign stride_b = ADDR_W'({pitch, 2'b00});
  assign line_end = run && hcnt >= h_last;

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> blank_o && pix_o == '0 && !mem_rd_o && !fmt_bad_o);

  a_r5_no_fetch_gated: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mem_rd_o);

  a_r1_hstep: assert property (@(posedge clk) disable iff (rst)
    run && hcnt < h_last |=> hcnt == $past(hcnt) + 1'b1);

  a_r1_hwrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> hcnt == '0);

  a_r2_vwrap: assert property (@(posedge clk) disable iff (rst)
    line_end && vcnt >= vtot |=> vcnt == '0 && row_base == $past(start_b));

  a_r3_row_step: assert property (@(posedge clk) disable iff (rst)
    line_end && vcnt < vtot |=> row_base == $past(row_base) + $past(stride_b));

  a_r4_blank_black: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> pix_o == '0);
endmodule

bind crtc_scanout crtc_scanout_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_w), .htot(cfg.htot), .vtot(cfg.vtot),
  .start(cfg.start), .pitch(cfg.pitch), .hcnt(hcnt_w), .vcnt(vcnt_w),
  .row_base(row_base_w), .mem_rd_o(mem_rd_o), .blank_o(blank_o),
  .pix_o(pix_o), .fmt_bad_o(fmt_bad_o)
);

// File: tb/crtc_scanout_bench.sv
module crtc_scanout_bench;
  localparam int ADDR_W = 24;
  localparam int WDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [3:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_rd_o;
  logic [7:0]        mem_q;
  logic              blank_o;
  logic [7:0]        pix_o;
  logic              fmt_bad_o;

  always #10 clk = ~clk;

  crtc_scanout #(.ADDR_W(ADDR_W), .RD_LAT(1), .PIX_W(8)) u_crtc_scanout (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_data_i(mem_q),
    .blank_o(blank_o), .pix_o(pix_o), .fmt_bad_o(fmt_bad_o)
  );

  function automatic logic [7:0] memf(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5a;
  endfunction

  // frame buffer model: one-cycle synchronous read
  always_ff @(posedge clk) mem_q <= memf(mem_addr_o);

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  bit  mon_on = 1'b0;
  int  cyc = 0, run_len = 0, runs = 0, nfall = 0, rd_seen = 0, vis_seen = 0;
  int  fall_t [16];
  bit  prev_blank = 1'b1;
  int  g_htot, g_hd, g_vt, g_vd, g_pitch;
  logic [19:0] g_start;
  bit  g_black, g_fmtbad;

  task automatic fail(input string req, input int act, input int exp, input string what);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) fail(req, act, exp, what);
  endtask

  // monitor: pops one expected index per visible pixel, measures runs and line starts
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (mem_rd_o) rd_seen++;
      if (!blank_o) begin
        vis_seen++;
        if (prev_blank) begin
          if (nfall < 16) fall_t[nfall] = cyc;
          nfall++;
          run_len = 0;
        end
        run_len++;
        checks++;
        if (exp_q.size() == 0) fail("R4", int'(pix_o), -1, "unexpected visible pixel");
        else begin
          logic [7:0] v;
          v = exp_q.pop_front();
          if (pix_o !== v) fail("R3", int'(pix_o), int'(v), "pixel index");
        end
      end else if (!prev_blank) begin
        runs++;
        check("R1", run_len, g_hd, "visible run length");
      end
      prev_blank = blank_o;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R10: wr_addr[3:2] = register, wr_addr[1:0] = byte lane
  task automatic configure(input logic [8:0] hf, input logic [7:0] hd, input logic [10:0] vt,
                           input logic [10:0] vd, input logic [19:0] st, input logic [9:0] pt,
                           input logic [2:0] fmt, input logic [7:0] ctl0);
    wr(4'hF, 8'h00);
    wr(4'h0, hf[7:0]);  wr(4'h1, {7'b0, hf[8]}); wr(4'h2, hd);
    wr(4'h4, vt[7:0]);  wr(4'h5, {5'b0, vt[10:8]});
    wr(4'h6, vd[7:0]);  wr(4'h7, {5'b0, vd[10:8]});
    wr(4'h8, st[7:0]);  wr(4'h9, st[15:8]);
    wr(4'hA, {pt[1:0], 2'b00, st[19:16]}); wr(4'hB, pt[9:2]);
    wr(4'hC, ctl0); wr(4'hD, {5'b0, fmt}); wr(4'hE, 8'h00);
    g_htot = (int'(hf) + 1) * 8; g_hd = (int'(hd) + 1) * 8;
    g_vt = int'(vt) + 1; g_vd = int'(vd) + 1;
    g_start = st; g_pitch = int'(pt);
    g_black = ctl0[6] || (fmt != 3'd2);
    g_fmtbad = (fmt != 3'd2);
  endtask

  task automatic run_frames(input int n, input bit late_h);
    logic [ADDR_W-1:0] a;
    for (int f = 0; f < n; f++)
      for (int y = 0; y < g_vd; y++)
        for (int x = 0; x < g_hd; x++) begin
          a = ADDR_W'({g_start, 3'b000}) + ADDR_W'(y * g_pitch * 4 + x);
          exp_q.push_back(g_black ? 8'h00 : memf(a));
        end
    runs = 0; nfall = 0; vis_seen = 0; rd_seen = 0; prev_blank = 1'b1;
    mon_on = 1'b1;
    wr(4'hF, 8'h03);
    if (late_h) wr(4'h2, 8'h00);
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(negedge clk);
    check("R7", int'(fmt_bad_o), int'(g_fmtbad), "fmt_bad_o while scanning");
    wr(4'hF, 8'h00);
    repeat (8) @(negedge clk);
    mon_on = 1'b0;
    check("R2", runs, n * g_vd, "visible lines seen");
    if (g_vd >= 2) check("R1", fall_t[1] - fall_t[0], g_htot, "line period");
    if (n >= 2) check("R2", fall_t[g_vd] - fall_t[g_vd-1], g_htot * (g_vt - g_vd + 1),
                      "last-to-next-frame line spacing");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9", int'(blank_o), 1, "blank_o after reset");
    check("R9", int'(pix_o), 0, "pix_o after reset");
    check("R9", int'(mem_rd_o), 0, "mem_rd_o after reset");
    check("R9", int'(fmt_bad_o), 0, "fmt_bad_o after reset");

    // basic raster: 24 clocks/line, 16 visible, 4 lines, 3 visible
    configure(9'd2, 8'd1, 11'd3, 11'd2, 20'd5, 10'd8, 3'd2, 8'h00);
    run_frames(2, 1'b0);

    // R10 upper lanes: vertical total bits 10:8, start nibble, split pitch
    configure(9'd2, 8'd1, 11'h100, 11'd1, 20'hA0003, 10'd6, 3'd2, 8'h00);
    run_frames(2, 1'b0);

    // R1 horizontal total bit 8, no vertical blanking
    configure(9'h100, 8'd0, 11'd0, 11'd0, 20'd17, 10'd3, 3'd2, 8'h00);
    run_frames(2, 1'b0);

    // R6 display off: zeros with normal timing
    configure(9'd2, 8'd1, 11'd3, 11'd2, 20'd9, 10'd5, 3'd2, 8'h40);
    run_frames(1, 1'b0);

    // R7 unsupported format, then back to 8bpp
    configure(9'd2, 8'd1, 11'd3, 11'd2, 20'd9, 10'd5, 3'd3, 8'h00);
    run_frames(1, 1'b0);
    configure(9'd2, 8'd1, 11'd3, 11'd2, 20'd9, 10'd5, 3'd2, 8'h00);
    run_frames(1, 1'b0);

    // R8: late horizontal write ignored until a redecode
    configure(9'd2, 8'd1, 11'd3, 11'd2, 20'd1, 10'd4, 3'd2, 8'h00);
    run_frames(2, 1'b1);
    g_hd = 8;
    run_frames(1, 1'b0);

    // R5: native-only and raster-only both keep scanout off
    for (int k = 0; k < 2; k++) begin
      vis_seen = 0; rd_seen = 0;
      mon_on = 1'b1;
      wr(4'hF, (k == 0) ? 8'h01 : 8'h02);
      repeat (100) @(negedge clk);
      mon_on = 1'b0;
      check("R5", vis_seen, 0, "visible cycles with scanout gated");
      check("R5", rd_seen, 0, "fetches with scanout gated");
      check("R5", int'(blank_o), 1, "blank_o with scanout gated");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fail("watchdog", WDOG, 0, "run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule